// File: doc/BRIEF.md
# Synchronous Bus Read Master with Wait States

This block runs memory read cycles on a clocked parallel bus. A requester gives it an address with a one-cycle start pulse. The master puts the address on the bus and then drives two active-low strobes, a memory request and a read strobe. It watches a wait line from the slave and takes the data word off the bus when the cycle ends. The captured word comes back to the requester with a one-cycle done pulse.

A plain read has three bus clocks, called T1, T2 and T3. The address appears in T1. The strobes go low from T2 until the end of T3. The slave can hold the cycle in a wait state for as many whole clocks as it needs by raising the wait line. The master samples that line only at the end of T2 and at the end of each wait state. The strobes go high again in the cycle after T3, which is the same cycle that carries the done pulse. A new start may be given in that cycle, so reads can run back to back.

Top module: `busrd_master`

## Requirements
- R1: While reset is held and right after it is released, `bus_mreq_n` and `bus_rd_n` are 1, `rsp_done` is 0 and `rsp_data` is 0.
- R2: A start pulse seen at a clock edge while the master is idle makes `bus_addr` equal the requested address in the next cycle (T1). Both strobes stay 1 during T1.
- R3: `bus_mreq_n` and `bus_rd_n` always have the same value. They are 0 exactly from T2 through T3, including any wait states, and they are 1 in the cycle that carries `rsp_done`.
- R4: With the wait line low when it is sampled, `rsp_done` goes to 1 in the fourth cycle after the edge that accepts the start. A start given in the done cycle is accepted.
- R5: Each clock edge at the end of T2 or of a wait state that samples `bus_wait` = 1 adds exactly one cycle to the read.
- R6: `rsp_data` in the done cycle equals the value `bus_data` had at the clock edge that ended T3. `rsp_done` is high for exactly one cycle.
- R7: A start pulse given while a read is in progress is ignored. The running read keeps its address and length, and no extra read follows it.
- R8: `bus_addr` does not change from T1 until the strobes are released.
- R9: `rsp_data` holds its value in every cycle that has no done pulse.
- R10: `bus_wait` is ignored in idle, T1, T3 and the done cycle. A high level there adds no cycle to the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_start | input | 1 | One-cycle start request |
| req_addr | input | ADDR_W | Address to read |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_data | output | DATA_W | Captured read data |
| bus_addr | output | ADDR_W | Address lines |
| bus_mreq_n | output | 1 | Memory request strobe, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wait | input | 1 | Slave wait request, active high |
| bus_data | input | DATA_W | Data lines from the slave |

## Verification
If the sequencer holds a wrong phase, the strobes show it within one cycle. They fall too early or too late, stay low in a wait state the slave never asked for, or fail to come back high together with the done pulse. A read that skips T3 or stays there too long moves the done pulse, and it also changes the captured word, because the bench's data lines change on every clock. A latched address that slips or gets overwritten by a second start shows up on `bus_addr` in the same cycle. The reference model compares every one of these ports on every clock, so none of these faults survives past the cycle in which it first appears.

// File: rtl/busrd_pkg.sv
package busrd_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_T1   = 3'd1,
        PH_T2   = 3'd2,
        PH_TW   = 3'd3,
        PH_T3   = 3'd4
    } phase_e;

endpackage

// File: rtl/busrd_seq.sv
module busrd_seq
    import busrd_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              wait_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic              mreq_n,
    output logic              rd_n,
    output logic              cap_en
);

    typedef struct packed {
        phase_e            ph;
        logic [ADDR_W-1:0] addr;
        logic              mreq_n;
        logic              rd_n;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.ph)
            PH_IDLE: begin
                if (start) begin
                    s_d.ph   = PH_T1;
                    s_d.addr = addr_in;
                end
            end
            PH_T1: begin
                s_d.ph     = PH_T2;
                s_d.mreq_n = 1'b0;
                s_d.rd_n   = 1'b0;
            end
            PH_T2, PH_TW: begin
                s_d.ph = wait_in ? PH_TW : PH_T3;
            end
            PH_T3: begin
                s_d.ph     = PH_IDLE;
                s_d.mreq_n = 1'b1;
                s_d.rd_n   = 1'b1;
            end
            default: begin
                s_d.ph     = PH_IDLE;
                s_d.mreq_n = 1'b1;
                s_d.rd_n   = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.ph     <= PH_IDLE;
            s_q.addr   <= '0;
            s_q.mreq_n <= 1'b1;
            s_q.rd_n   <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign addr_out = s_q.addr;
    assign mreq_n   = s_q.mreq_n;
    assign rd_n     = s_q.rd_n;
    assign cap_en   = (s_q.ph == PH_T3);

endmodule

// File: rtl/busrd_capture.sv
module busrd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] data_in,
    output logic              done,
    output logic [DATA_W-1:0] data_out
);

    typedef struct packed {
        logic              done;
        logic [DATA_W-1:0] data;
    } cap_t;

    cap_t c_d, c_q;

    always_comb begin
        c_d      = c_q;
        c_d.done = cap_en;
        if (cap_en) begin
            c_d.data = data_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q.done <= 1'b0;
            c_q.data <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign done     = c_q.done;
    assign data_out = c_q.data;

endmodule

// File: rtl/busrd_master.sv
module busrd_master #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_start,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_data,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_mreq_n,
    output logic              bus_rd_n,
    input  logic              bus_wait,
    input  logic [DATA_W-1:0] bus_data
);

    logic cap_en;

    busrd_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (req_start),
        .addr_in  (req_addr),
        .wait_in  (bus_wait),
        .addr_out (bus_addr),
        .mreq_n   (bus_mreq_n),
        .rd_n     (bus_rd_n),
        .cap_en   (cap_en)
    );

    busrd_capture #(.DATA_W(DATA_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (cap_en),
        .data_in  (bus_data),
        .done     (rsp_done),
        .data_out (rsp_data)
    );

endmodule

// File: rtl/busrd_master_chk.sv
module busrd_master_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rsp_done,
    input logic [DATA_W-1:0] rsp_data,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_mreq_n,
    input logic              bus_rd_n
);

    // R3
    strobe_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_mreq_n == bus_rd_n);

    // R3
    done_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> bus_mreq_n);

    // R6
    release_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_mreq_n) |-> rsp_done);

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R2
    addr_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_mreq_n) |-> $stable(bus_addr));

    // R8
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_mreq_n && !$past(bus_mreq_n)) |-> $stable(bus_addr));

    // R9
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_done |-> $stable(rsp_data));

endmodule

bind busrd_master busrd_master_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rsp_done   (rsp_done),
    .rsp_data   (rsp_data),
    .bus_addr   (bus_addr),
    .bus_mreq_n (bus_mreq_n),
    .bus_rd_n   (bus_rd_n)
);

// File: tb/sim_busrd_master.sv
`timescale 1ns/1ps
module sim_busrd_master;

    localparam int AW = 16;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_start = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          rsp_done;
    logic [DW-1:0] rsp_data;
    logic [AW-1:0] bus_addr;
    logic          bus_mreq_n;
    logic          bus_rd_n;
    logic          bus_wait = 1'b0;
    logic [DW-1:0] bus_data = 8'h11;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit finished = 0;
    bit cmp_on = 0;

    // slave stimulus settings
    int wait_req = 0;
    int wait_used = 0;
    bit noise = 0;

    // reference model
    bit          m_busy = 0;
    int          m_k = 0;
    int          m_ext = 0;
    bit          m_done = 0;
    logic [AW-1:0] m_addr = '0;
    logic [DW-1:0] m_data = '0;

    busrd_master #(.ADDR_W(AW), .DATA_W(DW)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_start  (req_start),
        .req_addr   (req_addr),
        .rsp_done   (rsp_done),
        .rsp_data   (rsp_data),
        .bus_addr   (bus_addr),
        .bus_mreq_n (bus_mreq_n),
        .bus_rd_n   (bus_rd_n),
        .bus_wait   (bus_wait),
        .bus_data   (bus_data)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // model: k counts cycles since acceptance, ext counts granted wait states
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy <= 0; m_k <= 0; m_ext <= 0; m_done <= 0;
            m_addr <= '0; m_data <= '0;
        end else begin
            m_done <= 0;
            if (m_busy) begin
                if (m_k == 3 + m_ext) begin
                    m_busy <= 0;
                    m_done <= 1;
                    m_data <= bus_data;
                end else begin
                    if (m_k == 2 + m_ext && bus_wait) m_ext <= m_ext + 1;
                    m_k <= m_k + 1;
                end
            end else if (req_start) begin
                m_busy <= 1; m_k <= 1; m_ext <= 0; m_addr <= req_addr;
            end
        end
    end

    // slave: data changes every clock, wait only where the model says T2/wait
    always @(negedge clk) begin
        bus_data <= bus_data + 8'h3B;
        if (!m_busy) wait_used <= 0;
        if (m_busy && m_k == 2 + m_ext) begin
            if (wait_used < wait_req) begin
                bus_wait  <= 1'b1;
                wait_used <= wait_used + 1;
            end else begin
                bus_wait <= 1'b0;
            end
        end else begin
            bus_wait <= noise;
        end
    end

    // per-cycle comparison against the model
    always @(posedge clk) begin
        #2;
        if (cmp_on && rst_n) begin
            bit exp_low;
            exp_low = m_busy && (m_k >= 2);
            check(bus_mreq_n == !exp_low, "R3 mreq_n", bus_mreq_n, !exp_low);
            check(bus_rd_n == !exp_low, "R3 rd_n", bus_rd_n, !exp_low);
            check(rsp_done == m_done, "R5 done timing", rsp_done, m_done);
            if (m_busy) check(bus_addr == m_addr, "R8 bus_addr", bus_addr, m_addr);
            if (m_done) check(rsp_data == m_data, "R6 captured data", rsp_data, m_data);
            else        check(rsp_data == m_data, "R9 data hold", rsp_data, m_data);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !finished) begin
            finished = 1;
            n_bad++;
            $display("FAIL watchdog act=%0d exp=<20000", cyc);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    task automatic do_read(input logic [AW-1:0] a, input int nw,
                           input bit nz, input bit inject);
        int n;
        string tag;
        wait_req = nw;
        noise = nz;
        @(negedge clk);
        req_start = 1'b1;
        req_addr = a;
        @(posedge clk);
        #2;
        req_start = 1'b0;
        n = 1;
        // T1: address out, strobes still high
        check(bus_addr == a, "R2 addr in T1", bus_addr, a);
        check(bus_mreq_n == 1'b1, "R2 strobe high in T1", bus_mreq_n, 1);
        while (!rsp_done && n < 50) begin
            @(posedge clk);
            #2;
            n++;
            if (inject && n == 2) begin
                req_start = 1'b1;
                req_addr = ~a;
            end
            if (inject && n == 3) req_start = 1'b0;
        end
        req_start = 1'b0;
        if (nw > 0)      tag = "R5 latency";
        else if (nz)     tag = "R10 latency";
        else if (inject) tag = "R7 latency";
        else             tag = "R4 latency";
        check(n == 4 + nw, tag, n, 4 + nw);
        noise = 0;
        wait_req = 0;
    endtask

    initial begin
        logic [DW-1:0] last;
        int dones;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        check(bus_mreq_n == 1'b1, "R1 mreq_n reset", bus_mreq_n, 1);
        check(bus_rd_n == 1'b1, "R1 rd_n reset", bus_rd_n, 1);
        check(rsp_done == 1'b0, "R1 done reset", rsp_done, 0);
        check(rsp_data == '0, "R1 data reset", rsp_data, 0);
        @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1;
        @(posedge clk);
        #2;
        check(bus_mreq_n == 1'b1 && rsp_done == 1'b0, "R1 after release",
              {bus_mreq_n, rsp_done}, 2'b10);

        do_read(16'h1234, 0, 0, 0);           // R4
        do_read(16'hBEEF, 0, 0, 0);           // R4 back to back
        do_read(16'h00A5, 1, 0, 0);           // R5
        do_read(16'hF00D, 3, 0, 0);           // R5
        do_read(16'h7E7E, 0, 1, 0);           // R10 wait high outside T2
        do_read(16'h4321, 2, 1, 0);           // R5 + R10
        do_read(16'h5A5A, 0, 0, 1);           // R7 start while busy

        // R7: no extra read after the ignored start
        dones = 0;
        repeat (6) begin
            @(posedge clk);
            #2;
            if (rsp_done || !bus_mreq_n) dones++;
        end
        check(dones == 0, "R7 no extra read", dones, 0);

        // R9: data stays after completion while idle
        last = rsp_data;
        repeat (5) @(posedge clk);
        #2;
        check(rsp_data == last, "R9 idle hold", rsp_data, last);

        do_read(16'h0001, 4, 1, 1);           // R5 with noise and injection
        repeat (3) @(posedge clk);

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule